// File: doc/BRIEF.md
# Multicast Sharer-Map Pruning Cache

This block sits in one switching element of the return network of a cache-coherent multiprocessor. It is a small fully associative store. Each entry holds a line address and a sharer map with one bit per switch output. Each packet header that passes through the switch is presented to the block once. When a line read-out packet passes, the block records the output port the packet leaves on. This builds an exact per-port picture of which outputs lead to copies of that line.

When an invalidation or update multicast for a cached line arrives, the block returns the recorded map as the output mask. The switch then sends copies only toward ports that really have sharers. On a miss, the coarse map carried in the header passes through unchanged. A miss therefore costs only extra packets and never a lost one. Replacement order depends on the protocol: allocation order under the invalidation protocol, recency of use under the update protocol. Every valid entry pushed out is reported toward memory with its line address, so memory can stop trusting pruning for that line.

Top module: `prune_cache`

## Requirements
- R1: After reset every entry is invalid, and `mc_valid` and `evict_valid` are low.
- R2: A read-out packet (`hdr_kind` = 2'b01) whose address matches a valid entry ORs the bit `hdr_port` into that entry's map.
- R3: A read-out packet that matches no entry allocates one. The lowest-indexed free entry is used when one exists. The new map holds only the bit `hdr_port`.
- R4: An invalidation (2'b10) or update (2'b11) header produces `mc_valid` on the next cycle. On a hit, `mc_hit`=1 and `mc_mask` is the stored map. On a miss, `mc_hit`=0 and `mc_mask` equals `hdr_map`.
- R5: An invalidation hit removes the entry after supplying its map. An update hit leaves the entry in place.
- R6: With `proto_upd`=0 and the store full, the victim is the entry allocated earliest; hits do not change the order.
- R7: With `proto_upd`=1 and the store full, the victim is the entry least recently used; read hits and update hits both count as use.
- R8: When a valid entry is replaced, `evict_valid` pulses on the next cycle with `evict_addr` set to the replaced line address. There is no pulse otherwise.
- R9: A read-out miss with `hdr_nofill`=1 allocates nothing and evicts nothing. A read-out hit with `hdr_nofill`=1 still records its port.
- R10: Read-out packets and headers with `hdr_kind`=2'b00 or `hdr_valid`=0 never raise `mc_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proto_upd | input | 1 | 0: invalidation protocol (FIFO); 1: update protocol (LRU) |
| hdr_valid | input | 1 | A header is presented this cycle |
| hdr_kind | input | 2 | 00 none, 01 read-out, 10 invalidation, 11 update |
| hdr_addr | input | ADDR_W | Line address |
| hdr_port | input | $clog2(N_PORT) | Output port taken by a read-out packet |
| hdr_map | input | N_PORT | Coarse multicast map from the header |
| hdr_nofill | input | 1 | Pruning forbidden for this line: do not allocate |
| mc_valid | output | 1 | Multicast mask valid |
| mc_hit | output | 1 | Mask came from the cache |
| mc_mask | output | N_PORT | Output mask for the multicast |
| evict_valid | output | 1 | A valid entry was replaced |
| evict_addr | output | ADDR_W | Line address of the replaced entry |

## Verification
The hardest state to reach is a full store whose recency order differs from its allocation order. That is the only state in which FIFO and LRU pick different victims. The stimulus fills all four entries in a known order, then re-reads the oldest line so that only LRU promotes it, and then forces one more allocation. The victim address reported on the eviction port distinguishes the two policies. Follow-up multicasts then confirm which lines remain stored.

// File: rtl/prune_pkg.sv
package prune_pkg;
    typedef enum logic [1:0] {
        K_NONE   = 2'b00,
        K_READ   = 2'b01,
        K_INVAL  = 2'b10,
        K_UPDATE = 2'b11
    } kind_e;
endpackage

// File: rtl/prune_match.sv
module prune_match #(
    parameter int N_ENTRY = 4,
    parameter int ADDR_W  = 16,
    localparam int IDX_W  = $clog2(N_ENTRY)
) (
    input  logic [N_ENTRY-1:0]             vld,
    input  logic [N_ENTRY-1:0][ADDR_W-1:0] tag,
    input  logic [ADDR_W-1:0]              addr,
    output logic [N_ENTRY-1:0]             hit_vec,
    output logic                           hit_any,
    output logic [IDX_W-1:0]               hit_idx
);
    genvar g;
    generate
        for (g = 0; g < N_ENTRY; g++) begin : g_cmp
            assign hit_vec[g] = vld[g] && (tag[g] == addr);
        end
    endgenerate

    assign hit_any = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int e = 0; e < N_ENTRY; e++)
            if (hit_vec[e]) hit_idx = IDX_W'(e);
    end
endmodule

// File: rtl/prune_victim.sv
module prune_victim #(
    parameter int N_ENTRY = 4,
    localparam int IDX_W  = $clog2(N_ENTRY)
) (
    input  logic [N_ENTRY-1:0]            vld,
    input  logic [N_ENTRY-1:0][IDX_W-1:0] age,
    output logic [IDX_W-1:0]              vic_idx
);
    logic found_free;

    always_comb begin
        vic_idx    = '0;
        found_free = 1'b0;
        // oldest entry by rank (used only when no slot is free)
        for (int e = 0; e < N_ENTRY; e++)
            if (age[e] == IDX_W'(N_ENTRY - 1)) vic_idx = IDX_W'(e);
        // lowest free slot wins over any eviction
        for (int e = N_ENTRY - 1; e >= 0; e--)
            if (!vld[e]) begin
                vic_idx    = IDX_W'(e);
                found_free = 1'b1;
            end
    end
endmodule

// File: rtl/prune_cache.sv
module prune_cache
    import prune_pkg::*;
#(
    parameter int N_ENTRY = 4,
    parameter int N_PORT  = 4,
    parameter int ADDR_W  = 16,
    localparam int IDX_W  = $clog2(N_ENTRY),
    localparam int PORT_W = $clog2(N_PORT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proto_upd,
    input  logic              hdr_valid,
    input  logic [1:0]        hdr_kind,
    input  logic [ADDR_W-1:0] hdr_addr,
    input  logic [PORT_W-1:0] hdr_port,
    input  logic [N_PORT-1:0] hdr_map,
    input  logic              hdr_nofill,
    output logic              mc_valid,
    output logic              mc_hit,
    output logic [N_PORT-1:0] mc_mask,
    output logic              evict_valid,
    output logic [ADDR_W-1:0] evict_addr
);
    typedef struct packed {
        logic [N_ENTRY-1:0]             vld;
        logic [N_ENTRY-1:0][ADDR_W-1:0] tag;
        logic [N_ENTRY-1:0][N_PORT-1:0] map;
        logic [N_ENTRY-1:0][IDX_W-1:0]  age;
        logic                           mc_v;
        logic                           mc_h;
        logic [N_PORT-1:0]              mc_m;
        logic                           ev_v;
        logic [ADDR_W-1:0]              ev_a;
    } st_t;

    st_t st_q, st_d;

    logic [N_ENTRY-1:0] hit_vec;
    logic               hit_any;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   vic_idx;

    prune_match #(.N_ENTRY(N_ENTRY), .ADDR_W(ADDR_W)) u_match (
        .vld(st_q.vld), .tag(st_q.tag), .addr(hdr_addr),
        .hit_vec(hit_vec), .hit_any(hit_any), .hit_idx(hit_idx)
    );

    prune_victim #(.N_ENTRY(N_ENTRY)) u_victim (
        .vld(st_q.vld), .age(st_q.age), .vic_idx(vic_idx)
    );

    kind_e             kind;
    logic [N_PORT-1:0] port_bit;
    logic              touch_en;
    logic [IDX_W-1:0]  touch_idx;

    assign kind     = kind_e'(hdr_kind);
    assign port_bit = N_PORT'(1) << hdr_port;

    always_comb begin
        st_d      = st_q;
        st_d.mc_v = 1'b0;
        st_d.mc_h = 1'b0;
        st_d.mc_m = '0;
        st_d.ev_v = 1'b0;
        st_d.ev_a = '0;
        touch_en  = 1'b0;
        touch_idx = '0;

        if (hdr_valid) begin
            case (kind)
                K_READ: begin
                    if (hit_any) begin
                        st_d.map[hit_idx] = st_q.map[hit_idx] | port_bit;
                        touch_en  = proto_upd;
                        touch_idx = hit_idx;
                    end else if (!hdr_nofill) begin
                        if (st_q.vld[vic_idx]) begin
                            st_d.ev_v = 1'b1;
                            st_d.ev_a = st_q.tag[vic_idx];
                        end
                        st_d.vld[vic_idx] = 1'b1;
                        st_d.tag[vic_idx] = hdr_addr;
                        st_d.map[vic_idx] = port_bit;
                        touch_en  = 1'b1;
                        touch_idx = vic_idx;
                    end
                end
                K_INVAL, K_UPDATE: begin
                    st_d.mc_v = 1'b1;
                    st_d.mc_h = hit_any;
                    st_d.mc_m = hit_any ? st_q.map[hit_idx] : hdr_map;
                    if (hit_any) begin
                        if (kind == K_INVAL) begin
                            st_d.vld[hit_idx] = 1'b0;
                        end else begin
                            touch_en  = proto_upd;
                            touch_idx = hit_idx;
                        end
                    end
                end
                default: ;
            endcase
        end

        // rank update: touched entry becomes youngest, younger ones age by one
        if (touch_en) begin
            for (int e = 0; e < N_ENTRY; e++) begin
                if (IDX_W'(e) == touch_idx)
                    st_d.age[e] = '0;
                else if (st_q.age[e] < st_q.age[touch_idx])
                    st_d.age[e] = st_q.age[e] + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int e = 0; e < N_ENTRY; e++)
                st_q.age[e] <= IDX_W'(e);
        end else begin
            st_q <= st_d;
        end
    end

    assign mc_valid    = st_q.mc_v;
    assign mc_hit      = st_q.mc_h;
    assign mc_mask     = st_q.mc_m;
    assign evict_valid = st_q.ev_v;
    assign evict_addr  = st_q.ev_a;
endmodule

// File: rtl/prune_cache_chk.sv
module prune_cache_chk #(
    parameter int N_ENTRY = 4,
    parameter int N_PORT  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hdr_valid,
    input logic [1:0]         hdr_kind,
    input logic [N_PORT-1:0]  hdr_map,
    input logic               hdr_nofill,
    input logic               mc_valid,
    input logic               mc_hit,
    input logic [N_PORT-1:0]  mc_mask,
    input logic               evict_valid,
    input logic [N_ENTRY-1:0] hit_vec
);
    logic is_mc, is_rd;
    assign is_mc = hdr_valid && hdr_kind[1];
    assign is_rd = hdr_valid && (hdr_kind == 2'b01);

    a_r10_no_mc_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !is_mc |=> !mc_valid);

    a_r4_mc_follows: assert property (@(posedge clk) disable iff (!rst_n)
        is_mc |=> mc_valid);

    a_r4_miss_uses_header: assert property (@(posedge clk) disable iff (!rst_n)
        is_mc |=> (mc_hit || mc_mask == $past(hdr_map)));

    a_r8_evict_only_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> !evict_valid);

    a_r9_nofill_no_evict: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && hdr_nofill) |=> !evict_valid);

    a_r3_unique_tag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

bind prune_cache prune_cache_chk #(.N_ENTRY(N_ENTRY), .N_PORT(N_PORT)) u_chk (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_kind(hdr_kind),
    .hdr_map(hdr_map), .hdr_nofill(hdr_nofill), .mc_valid(mc_valid),
    .mc_hit(mc_hit), .mc_mask(mc_mask), .evict_valid(evict_valid),
    .hit_vec(hit_vec)
);

// File: tb/sim_prune_cache.sv
module sim_prune_cache;
    localparam int ADDR_W = 16;
    localparam int N_PORT = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              proto_upd = 1'b0;
    logic              hdr_valid = 1'b0;
    logic [1:0]        hdr_kind = 2'b00;
    logic [ADDR_W-1:0] hdr_addr = '0;
    logic [1:0]        hdr_port = '0;
    logic [N_PORT-1:0] hdr_map = '0;
    logic              hdr_nofill = 1'b0;
    logic              mc_valid, mc_hit, evict_valid;
    logic [N_PORT-1:0] mc_mask;
    logic [ADDR_W-1:0] evict_addr;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    prune_cache u0 (
        .clk(clk), .rst_n(rst_n), .proto_upd(proto_upd), .hdr_valid(hdr_valid),
        .hdr_kind(hdr_kind), .hdr_addr(hdr_addr), .hdr_port(hdr_port),
        .hdr_map(hdr_map), .hdr_nofill(hdr_nofill), .mc_valid(mc_valid),
        .mc_hit(mc_hit), .mc_mask(mc_mask), .evict_valid(evict_valid),
        .evict_addr(evict_addr)
    );

    localparam logic [15:0] LA = 16'h1000, LB = 16'h2000, LC = 16'h3000,
                            LD = 16'h4000, LE = 16'h5000;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic upd);
        @(negedge clk);
        proto_upd = upd;
        rst_n = 1'b0;
        hdr_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive one header; outputs for it are visible just after the next edge
    task automatic send(input logic [1:0] k, input logic [15:0] a,
                        input logic [1:0] p, input logic [3:0] m, input logic nf);
        @(negedge clk);
        hdr_valid = 1'b1; hdr_kind = k; hdr_addr = a;
        hdr_port = p; hdr_map = m; hdr_nofill = nf;
        @(posedge clk);
        #1;
        hdr_valid = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [1:0] p);
        send(2'b01, a, p, 4'h0, 1'b0);
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        #1;
        chk("R1 mc_valid", int'(mc_valid), 0);
        chk("R1 evict_valid", int'(evict_valid), 0);
        send(2'b10, LA, 2'd0, 4'hF, 1'b0);
        chk("R1 empty miss", int'(mc_hit), 0);
    endtask

    task automatic t_learn;
        do_reset(1'b0);
        rd(LA, 2'd0);
        chk("R10 read no mc", int'(mc_valid), 0);
        chk("R8 fill free no evict", int'(evict_valid), 0);
        rd(LA, 2'd2);
        send(2'b00, LA, 2'd0, 4'hF, 1'b0);
        chk("R10 kind none", int'(mc_valid), 0);
        send(2'b10, LA, 2'd0, 4'hF, 1'b0);
        chk("R4 hit valid", int'(mc_valid), 1);
        chk("R4 hit flag", int'(mc_hit), 1);
        chk("R2 map", int'(mc_mask), 5);
        send(2'b10, LA, 2'd0, 4'hB, 1'b0);
        chk("R5 removed after inval", int'(mc_hit), 0);
        chk("R4 miss header map", int'(mc_mask), 'hB);
        rd(LB, 2'd3);
        send(2'b11, LB, 2'd0, 4'hF, 1'b0);
        chk("R3 new map", int'(mc_mask), 8);
    endtask

    task automatic t_fifo;
        do_reset(1'b0);
        rd(LA, 2'd0); rd(LB, 2'd1); rd(LC, 2'd2); rd(LD, 2'd3);
        chk("R8 fourth fill no evict", int'(evict_valid), 0);
        rd(LA, 2'd3);
        rd(LE, 2'd1);
        chk("R8 evict pulse", int'(evict_valid), 1);
        chk("R6 fifo victim", int'(evict_addr), int'(LA));
        send(2'b10, LB, 2'd0, 4'hF, 1'b0);
        chk("R6 B kept", int'(mc_mask), 2);
        send(2'b11, LA, 2'd0, 4'h7, 1'b0);
        chk("R6 A gone", int'(mc_hit), 0);
    endtask

    task automatic t_lru;
        do_reset(1'b1);
        rd(LA, 2'd0); rd(LB, 2'd1); rd(LC, 2'd2); rd(LD, 2'd3);
        rd(LA, 2'd0);
        rd(LE, 2'd1);
        chk("R7 lru victim", int'(evict_addr), int'(LB));
        send(2'b11, LA, 2'd0, 4'hF, 1'b0);
        chk("R7 A kept", int'(mc_mask), 1);
        send(2'b11, LA, 2'd0, 4'hF, 1'b0);
        chk("R5 update keeps", int'(mc_hit), 1);
        // C now oldest (A refreshed by update, E newer, D newer than C)
        rd(LB, 2'd2);
        chk("R7 victim after update", int'(evict_addr), int'(LC));
    endtask

    task automatic t_nofill;
        do_reset(1'b0);
        send(2'b01, LA, 2'd0, 4'h0, 1'b1);
        chk("R9 no evict", int'(evict_valid), 0);
        send(2'b11, LA, 2'd0, 4'hF, 1'b0);
        chk("R9 no alloc", int'(mc_hit), 0);
        rd(LA, 2'd1);
        send(2'b01, LA, 2'd2, 4'h0, 1'b1);
        send(2'b10, LA, 2'd0, 4'hF, 1'b0);
        chk("R9 hit records", int'(mc_mask), 6);
        rd(LA, 2'd0); rd(LB, 2'd1); rd(LC, 2'd2); rd(LD, 2'd3);
        send(2'b01, LE, 2'd0, 4'h0, 1'b1);
        chk("R9 full no evict", int'(evict_valid), 0);
        send(2'b11, LA, 2'd0, 4'hF, 1'b0);
        chk("R9 A survives", int'(mc_hit), 1);
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset;
        t_learn;
        t_fifo;
        t_lru;
        t_nofill;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule